// File: doc/BRIEF.md
# I2C Register-Map Slave

This block is an I2C slave that gives a bus master write and read access to a bank of 256 byte-wide registers. The registers themselves live outside the block. A plain register-file port carries the current pointer, the write strobe and data, and the read data. SCL and SDA are sampled on a fast system clock, which must run at least 16 times the SCL rate. Each line passes through a two-flop synchronizer and a three-sample glitch filter, and bus edges are taken from the filtered levels. The block never stretches the clock, so it works at standard and fast bus rates without wait states.

The device answers to a 7-bit address. Its upper six bits are fixed at 001101, and the lowest bit comes from a strap pin, so two of these slaves can share one bus (0x1A or 0x1B). A write carries the device address, then a register pointer byte, then any number of data bytes. A read returns bytes starting at the current pointer. In both directions the pointer steps by one after each data byte. SDA is driven only through an open-drain pull-down enable.

Top module: `i2cRegSlave`

## Requirements
- R1: The slave pulls SDA low for the ninth clock of the address byte only when the seven received bits equal {001101, addrStrap}. The eighth bit is R/W, where 0 means write and 1 means read.
- R2: After an address that does not match, the slave drives nothing and writes nothing until the next START or STOP.
- R3: In a write, the first byte after the address loads the register pointer. It is acknowledged and causes no register write.
- R4: Each later write byte is presented with regWrEn high for one cycle at the current pointer and is acknowledged. The pointer then increments, wrapping from 0xFF to 0x00.
- R5: A write burst may carry any number of data bytes. It ends only at a STOP.
- R6: In a read, the slave sends the byte at the pointer MSB first, changing SDA only after SCL falls. The pointer increments per byte, and a master ACK (SDA low on the ninth clock) requests the next byte.
- R7: After a master NACK (SDA high on the ninth clock), the slave releases SDA and drives nothing until the next START.
- R8: A repeated START at any bit position discards the byte in progress and restarts at the address byte.
- R9: Pulses on SCL or SDA shorter than three system clocks after synchronization are ignored.
- R10: sdaOe (1 = pull SDA low) is 0 out of reset and changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| addrStrap | input | 1 | Lowest device address bit |
| sdaOe | output | 1 | Open-drain enable: 1 pulls SDA low |
| regAddr | output | 8 | Register pointer, used for both read and write |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Byte to write at regAddr |
| regRdData | input | 8 | Register content at regAddr |

## Verification
The embedded assertions check on every cycle that the filtered lines hold for at least two cycles after each change. They also check that the SDA enable moves only after SCL has gone low, that ACK drive and data drive never overlap, that an ignoring slave stays silent, and that the pointer moves only on a pointer load, a write or a read load. Only the bench scenarios can show end-to-end behaviour. That covers address matching for both strap values, pointer wrap, long bursts, read-back with ACK and NACK, a repeated START mid-byte, and glitches that must not corrupt a byte.

// File: rtl/i2cSlvPkg.sv
`timescale 1ns/1ps
package i2cSlvPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    sIdle, sRecv, sWaitAck, sAckOut, sSend, sAckIn, sLoadTx
  } slvState_t;

  typedef enum logic [1:0] { kAddr, kPtr, kData } byteKind_t;

  typedef struct packed {
    logic shiftRx;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/i2cLineFilter.sv
`timescale 1ns/1ps
module i2cLineFilter #(
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut,
  output logic lineRise,
  output logic lineFall
);
  logic [SYNC_LEN-1:0] syncQ;
  logic [FILT_LEN-1:0] histQ;
  logic filtQ, prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '1;
      histQ <= '1;
      filtQ <= 1'b1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_LEN-2:0], lineIn};
      histQ <= {histQ[FILT_LEN-2:0], syncQ[SYNC_LEN-1]};
      if (&histQ)       filtQ <= 1'b1;
      else if (~|histQ) filtQ <= 1'b0;
      prevQ <= filtQ;
    end
  end

  assign lineOut  = filtQ;
  assign lineRise = filtQ & ~prevQ;
  assign lineFall = ~filtQ & prevQ;

  // R9: a filtered change needs a full run of agreeing samples, so no back-to-back toggles
  assert_filter_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $changed(filtQ) |=> $stable(filtQ));
endmodule

// File: rtl/i2cSlvData.sv
`timescale 1ns/1ps
module i2cSlvData
  import i2cSlvPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic              sdaF,
  input  logic              sclF,
  input  logic              ackDrive,
  input  logic              txActive,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxNext,
  output logic [BYTE_W-1:0] ptr,
  output logic              sdaOe
);
  logic [BYTE_W-1:0] rxQ, txQ, ptrQ;

  assign rxNext = {rxQ[BYTE_W-2:0], sdaF};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxQ  <= '0;
      txQ  <= '1;
      ptrQ <= '0;
    end else begin
      if (st.shiftRx) rxQ <= rxNext;
      if (st.loadPtr) ptrQ <= rxNext;
      else if (st.writeReg || st.loadTx) ptrQ <= ptrQ + 1'b1;
      if (st.loadTx) txQ <= regRdData;
      else if (st.shiftTx) txQ <= {txQ[BYTE_W-2:0], 1'b1};
    end
  end

  assign ptr   = ptrQ;
  assign sdaOe = ackDrive | (txActive & ~txQ[BYTE_W-1]);

  // R10: the pull-down enable only moves after SCL has been seen low
  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaOe) |-> !$past(sclF));

  // R4: the pointer moves only on a pointer load, a write or a read load
  assert_ptr_moves_R4: assert property (@(posedge clk) disable iff (!rstN)
    $changed(ptrQ) |-> $past(st.loadPtr | st.writeReg | st.loadTx));
endmodule

// File: rtl/i2cSlvCtrl.sv
`timescale 1ns/1ps
module i2cSlvCtrl
  import i2cSlvPkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b001101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              sdaF,
  input  logic              sdaRise,
  input  logic              sdaFall,
  input  logic              addrStrap,
  input  logic [BYTE_W-1:0] rxNext,
  output dpStrobe_t         st,
  output logic              ackDrive,
  output logic              txActive,
  output logic              regWrEn
);
  slvState_t       stateQ;
  byteKind_t       kindQ;
  logic [CNT_W-1:0] bitCntQ;
  logic            rwQ, ackDriveQ, txActiveQ;

  logic startDet, stopDet, addrHit, lastBit;
  assign startDet = sdaFall & sclF;
  assign stopDet  = sdaRise & sclF;
  assign addrHit  = (rxNext[BYTE_W-1:1] == {ADDR_HI, addrStrap});
  assign lastBit  = (bitCntQ == LAST_BIT);

  always_comb begin
    st = '0;
    if (!startDet && !stopDet) begin
      unique case (stateQ)
        sRecv: if (sclRise) begin
          st.shiftRx = 1'b1;
          if (lastBit && kindQ == kPtr)  st.loadPtr  = 1'b1;
          if (lastBit && kindQ == kData) st.writeReg = 1'b1;
        end
        sAckOut: if (sclFall && rwQ) st.loadTx = 1'b1;
        sLoadTx: if (sclFall) st.loadTx = 1'b1;
        sSend:   if (sclFall && !lastBit) st.shiftTx = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= sIdle;
      kindQ     <= kAddr;
      bitCntQ   <= '0;
      rwQ       <= 1'b0;
      ackDriveQ <= 1'b0;
      txActiveQ <= 1'b0;
    end else if (startDet) begin
      stateQ    <= sRecv;
      kindQ     <= kAddr;
      bitCntQ   <= '0;
      rwQ       <= 1'b0;
      ackDriveQ <= 1'b0;
      txActiveQ <= 1'b0;
    end else if (stopDet) begin
      stateQ    <= sIdle;
      ackDriveQ <= 1'b0;
      txActiveQ <= 1'b0;
    end else begin
      unique case (stateQ)
        sRecv: if (sclRise) begin
          bitCntQ <= bitCntQ + 1'b1;
          if (lastBit) begin
            if (kindQ != kAddr) stateQ <= sWaitAck;
            else if (addrHit) begin
              rwQ    <= rxNext[0];
              stateQ <= sWaitAck;
            end else stateQ <= sIdle;
          end
        end
        sWaitAck: if (sclFall) begin
          ackDriveQ <= 1'b1;
          stateQ    <= sAckOut;
        end
        sAckOut: if (sclFall) begin
          ackDriveQ <= 1'b0;
          bitCntQ   <= '0;
          if (rwQ) begin
            txActiveQ <= 1'b1;
            stateQ    <= sSend;
          end else begin
            stateQ <= sRecv;
            kindQ  <= (kindQ == kAddr) ? kPtr : kData;
          end
        end
        sSend: if (sclFall) begin
          bitCntQ <= bitCntQ + 1'b1;
          if (lastBit) begin
            txActiveQ <= 1'b0;
            stateQ    <= sAckIn;
          end
        end
        sAckIn: if (sclRise) stateQ <= sdaF ? sIdle : sLoadTx;
        sLoadTx: if (sclFall) begin
          txActiveQ <= 1'b1;
          bitCntQ   <= '0;
          stateQ    <= sSend;
        end
        default: ;
      endcase
    end
  end

  assign ackDrive = ackDriveQ;
  assign txActive = txActiveQ;
  assign regWrEn  = st.writeReg;

  // R2/R7: an idle slave never drives the bus
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == sIdle) |-> (!ackDriveQ && !txActiveQ));

  // R6: ACK drive and read-data drive never overlap
  assert_drive_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDriveQ && txActiveQ));

  // R4: register writes land while the filtered SCL is high (on the 8th rising edge)
  assert_write_scl_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> sclF);
endmodule

// File: rtl/i2cRegSlave.sv
`timescale 1ns/1ps
module i2cRegSlave
  import i2cSlvPkg::*;
#(
  parameter logic [5:0] ADDR_HI  = 6'b001101,
  parameter int         SYNC_LEN = 2,
  parameter int         FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData
);
  logic sclF, sclRise, sclFall, sdaF, sdaRise, sdaFall;
  logic ackDrive, txActive;
  logic [BYTE_W-1:0] rxNext;
  dpStrobe_t st;

  i2cLineFilter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) i_sclFilt (
    .clk(clk), .rstN(rstN), .lineIn(sclIn),
    .lineOut(sclF), .lineRise(sclRise), .lineFall(sclFall));

  i2cLineFilter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) i_sdaFilt (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn),
    .lineOut(sdaF), .lineRise(sdaRise), .lineFall(sdaFall));

  i2cSlvCtrl #(.ADDR_HI(ADDR_HI)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sclRise(sclRise), .sclFall(sclFall),
    .sdaF(sdaF), .sdaRise(sdaRise), .sdaFall(sdaFall), .addrStrap(addrStrap),
    .rxNext(rxNext), .st(st), .ackDrive(ackDrive), .txActive(txActive),
    .regWrEn(regWrEn));

  i2cSlvData i_data (
    .clk(clk), .rstN(rstN), .st(st), .sdaF(sdaF), .sclF(sclF),
    .ackDrive(ackDrive), .txActive(txActive), .regRdData(regRdData),
    .rxNext(rxNext), .ptr(regAddr), .sdaOe(sdaOe));

  assign regWrData = rxNext;
endmodule

// File: tb/test_i2cRegSlave.sv
`timescale 1ns/1ps
module test_i2cRegSlave;
  localparam int Q = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, sclDrv = 1'b1, sdaDrv = 1'b1, strap = 1'b0;
  logic sdaOe, regWrEn;
  logic [7:0] regAddr, regWrData, regRdData;
  logic sdaBus;
  logic [7:0] mem [0:255];
  logic [15:0] expQ[$];
  int checks = 0, fails = 0;

  assign sdaBus    = sdaDrv & ~sdaOe;
  assign regRdData = mem[regAddr];

  i2cRegSlave i_i2cRegSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaBus), .addrStrap(strap),
    .sdaOe(sdaOe), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every register write must match the next expected item (R2, R4, R5)
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expQ.size() == 0) check(1'b0, "R2 unexpected write", {regAddr, regWrData}, 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        check({regAddr, regWrData} == e, "R4 write addr/data", {regAddr, regWrData}, e);
      end
      mem[regAddr] = regWrData;
    end
  end

  // R10: enable changes only while the SCL pin is low
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe) check(sclDrv == 1'b0, "R10 oe moved with SCL high", sclDrv, 0);
    prevOe = sdaOe;
  end

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b0; waitQ();
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b1; waitQ(); sdaDrv = 1'b1; waitQ();
  endtask

  task automatic wrByte(input logic [7:0] b, input int nbits, input int glitchAt, output bit acked);
    acked = 1'b0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sdaDrv = b[i];
      if (i == glitchAt) begin
        repeat (3) @(negedge clk); sclDrv = 1'b1;
        repeat (2) @(negedge clk); sclDrv = 1'b0;
        repeat (Q - 5) @(negedge clk);
      end else waitQ();
      sclDrv = 1'b1; waitQ();
      if (i == glitchAt) begin
        sdaDrv = ~b[i]; repeat (2) @(negedge clk); sdaDrv = b[i];
        repeat (Q - 2) @(negedge clk);
      end else waitQ();
      sclDrv = 1'b0; waitQ();
    end
    if (nbits == 8) begin
      sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
      acked = (sdaBus == 1'b0); waitQ(); sclDrv = 1'b0; waitQ();
    end
  endtask

  task automatic rdByte(input bit masterAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
      b[i] = sdaBus; waitQ(); sclDrv = 1'b0; waitQ();
    end
    sdaDrv = ~masterAck; waitQ(); sclDrv = 1'b1; waitQ(); waitQ(); sclDrv = 1'b0; waitQ();
    sdaDrv = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] rd, e;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (10) @(negedge clk);
    check(sdaOe == 1'b0, "R10 reset oe", sdaOe, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(sdaOe == 1'b0, "R10 idle oe", sdaOe, 0);

    // R1 R3 R4: strap 0, address 0x1A write
    startCond();
    wrByte(8'h34, 8, -1, a); check(a, "R1 ack 0x1A", a, 1);
    wrByte(8'h10, 8, -1, a); check(a, "R3 ptr ack", a, 1);
    for (int k = 0; k < 3; k++) begin
      expQ.push_back({8'(8'h10 + k), 8'(8'hA0 + k)});
      wrByte(8'(8'hA0 + k), 8, -1, a); check(a, "R4 data ack", a, 1);
    end
    stopCond();
    check(expQ.size() == 0, "R4 writes done", expQ.size(), 0);

    // R2: mismatching address is ignored
    startCond();
    wrByte(8'h36, 8, -1, a); check(!a, "R2 no ack 0x1B", a, 0);
    wrByte(8'h20, 8, -1, a); check(!a, "R2 ignored ptr", a, 0);
    wrByte(8'h55, 8, -1, a); check(!a, "R2 ignored data", a, 0);
    stopCond();

    // R1 strap 1; R4 wrap
    strap = 1'b1; repeat (4) @(negedge clk);
    startCond();
    wrByte(8'h34, 8, -1, a); check(!a, "R1 0x1A rejected with strap 1", a, 0);
    stopCond();
    startCond();
    wrByte(8'h36, 8, -1, a); check(a, "R1 ack 0x1B", a, 1);
    wrByte(8'hFE, 8, -1, a); check(a, "R3 ptr ack", a, 1);
    expQ.push_back(16'hFE11); expQ.push_back(16'hFF22); expQ.push_back(16'h0033);
    wrByte(8'h11, 8, -1, a); wrByte(8'h22, 8, -1, a);
    wrByte(8'h33, 8, -1, a); check(a, "R4 wrap ack", a, 1);
    stopCond();
    check(expQ.size() == 0, "R4 wrap writes", expQ.size(), 0);
    strap = 1'b0; repeat (4) @(negedge clk);

    // R5: long burst
    startCond();
    wrByte(8'h34, 8, -1, a);
    wrByte(8'h40, 8, -1, a);
    for (int k = 0; k < 20; k++) begin
      expQ.push_back({8'(8'h40 + k), 8'(8'hC3 ^ k)});
      wrByte(8'(8'hC3 ^ k), 8, -1, a); check(a, "R5 burst ack", a, 1);
    end
    stopCond();
    check(expQ.size() == 0, "R5 burst writes", expQ.size(), 0);

    // R6 R7 R8: pointer then repeated START into a read
    startCond();
    wrByte(8'h34, 8, -1, a);
    wrByte(8'h11, 8, -1, a);
    startCond();
    wrByte(8'h35, 8, -1, a); check(a, "R8 ack after restart", a, 1);
    for (int k = 0; k < 3; k++) begin
      e = mem[8'h11 + k];
      rdByte(k != 2, rd); check(rd == e, "R6 read data", rd, e);
    end
    rdByte(1'b0, rd); check(rd == 8'hFF, "R7 released after nack", rd, 8'hFF);
    stopCond();
    startCond();
    wrByte(8'h35, 8, -1, a);
    e = mem[8'h14];
    rdByte(1'b0, rd); check(rd == e, "R6 pointer kept after read", rd, e);
    stopCond();

    // R8: repeated START in the middle of a data byte
    startCond();
    wrByte(8'h34, 8, -1, a);
    wrByte(8'h60, 8, -1, a);
    wrByte(8'h99, 4, -1, a);
    startCond();
    wrByte(8'h34, 8, -1, a); check(a, "R8 restart mid byte", a, 1);
    wrByte(8'h61, 8, -1, a);
    expQ.push_back(16'h6177);
    wrByte(8'h77, 8, -1, a);
    stopCond();
    check(expQ.size() == 0, "R8 single write", expQ.size(), 0);

    // R9: short glitches on both lines inside a data byte
    startCond();
    wrByte(8'h34, 8, -1, a);
    wrByte(8'h70, 8, -1, a);
    expQ.push_back(16'h703C);
    wrByte(8'h3C, 8, 3, a); check(a, "R9 ack despite glitch", a, 1);
    stopCond();
    check(expQ.size() == 0, "R9 write intact", expQ.size(), 0);
    check(sdaOe == 1'b0, "R10 idle after stop", sdaOe, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule